// File: doc/BRIEF.md
# CPU Address Window Decoder

This block holds the programmable decode fields for two CPU-side address windows. One is an I/O window that opens into PCI space. The other is a fixed-size window onto the chip's internal register file. Each window is placed in 2 MiB granules. A start field and an end field define the I/O window. One field places the internal window, which is always 4 KiB long.

From these fields the block derives each window's base and length and keeps both windows clear of two reserved system holes. It then compares a CPU address against both windows. The results are a hit flag per window, the offset of the address inside the window that matched, and the stored remap value that accompanies the I/O window.

Software programs the block through a small indexed write/read port and reads back every field with its masked value. The I/O mapping changes only when the new start and end fields are consistent. An inconsistent pair leaves the previous mapping active, so the two fields can be rewritten one after the other.

Top module: `cpu_window_decoder`

## Requirements
- R1: A write to index 0 (I/O start field) keeps bits 14:0 of the data. Reading index 0 returns that value zero-extended to 32 bits. A cycle with the write strobe low changes nothing.
- R2: A write to index 0 also loads the remap value with bits 10:0 of the data. A write to index 3 loads only the remap value, with bits 10:0 kept, and leaves both windows unchanged. Reading index 3 returns the remap value.
- R3: A write to index 1 (I/O end field) keeps bits 6:0 of the data. Reading index 1 returns that value.
- R4: The I/O window base is the start field shifted left by 21. Its length is (end + 1 − start[6:0]) shifted left by 21. The I/O hit is high exactly when base ≤ address < base + length and the length is nonzero.
- R5: After a write to index 0 or 1, the I/O mapping is taken from the new field pair only if start[6:0] ≤ end. Otherwise the previous mapping stays in force. Either way, the result is visible on the cycle after the write edge.
- R6: A write to index 2 keeps bits 14:0. The internal window base is that field shifted left by 21, and its length is 4 KiB.
- R7: A window start inside 0x1E000000–0x1F0FFFFF moves to 0x1F100000. A start inside 0x1FC00000–0x1FCFFFFF moves to 0x1FD00000.
- R8: A window end that falls inside a reserved hole is cut back to that hole's first address. A window that starts below a hole and ends past it is cut back in the same way. When the clipped end is not above the clipped start, the window has zero length and never hits.
- R9: The offset output is the address minus the base of the window that hits. The internal window takes priority when both hit. The offset is zero when neither window hits.
- R10: After reset, the fields are: start 0x080, end 0x0F, internal 0x0A0 and remap 0x080. This places the I/O window at 0x10000000 with a length of 32 MiB and the internal window at 0x14000000.
- R11: A window that ends exactly at the top of the 36-bit address space hits at the highest address and does not wrap around to low addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the field selected by reg_idx |
| reg_idx | input | 2 | Field index: 0 I/O start, 1 I/O end, 2 internal window, 3 remap |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read-back of the indexed field, zero-extended |
| cpu_addr | input | 36 | CPU address to decode |
| io_hit | output | 1 | Address lies inside the I/O window |
| isd_hit | output | 1 | Address lies inside the internal register window |
| win_offset | output | 36 | Address relative to the base of the matching window |
| remap_val | output | 11 | Current remap value |

## Verification
The first pattern probes the reset mapping at its first and last bytes and one byte past its end, which pins down both the base and the length arithmetic. Next come field pairs that are written in an inconsistent order. These show whether the previous mapping is really kept, as opposed to being recomputed or cleared. Windows are then placed with their start in each hole, with their end in a hole, and ending at the top of the address space. Each of these exercises a different clip rule or the carry into bit 36. Finally, overlapping windows and remap-only writes separate the offset priority from the mapping logic.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

    localparam int unsigned CFG_W   = 32;
    localparam int unsigned NWIN    = 2;
    localparam int unsigned WIN_IO  = 0;
    localparam int unsigned WIN_ISD = 1;

    typedef enum logic [1:0] {
        SEL_IO_LO = 2'd0,
        SEL_IO_HI = 2'd1,
        SEL_ISD   = 2'd2,
        SEL_REMAP = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/win_clip.sv
module win_clip #(
    parameter int unsigned     AW     = 36,
    parameter logic [AW-1:0]   HA_LO  = '0,
    parameter logic [AW-1:0]   HA_END = '0,
    parameter logic [AW-1:0]   HB_LO  = '0,
    parameter logic [AW-1:0]   HB_END = '0
) (
    input  logic [AW-1:0] base_i,
    input  logic [AW:0]   len_i,
    output logic [AW-1:0] base_o,
    output logic [AW:0]   len_o
);

    localparam logic [AW:0] A_LO  = {1'b0, HA_LO};
    localparam logic [AW:0] A_END = {1'b0, HA_END};
    localparam logic [AW:0] B_LO  = {1'b0, HB_LO};
    localparam logic [AW:0] B_END = {1'b0, HB_END};

    logic [AW:0] beg_v;
    logic [AW:0] end_v;

    // Order of the steps matters: each rule sees the result of the previous one.
    always_comb begin
        beg_v = {1'b0, base_i};
        end_v = beg_v + len_i;
        if (end_v >= A_LO && end_v < A_END) end_v = A_LO;
        if (beg_v >= A_LO && beg_v < A_END) beg_v = A_END;
        if (end_v >= B_LO && end_v < B_END) end_v = B_LO;
        if (beg_v >= B_LO && beg_v < B_END) beg_v = B_END;
        if (end_v >= A_END && beg_v < A_LO) end_v = A_LO;
        if (end_v >= B_END && beg_v < B_LO) end_v = B_LO;
        base_o = beg_v[AW-1:0];
        len_o  = (end_v > beg_v) ? (end_v - beg_v) : '0;
    end

endmodule

// File: rtl/win_match.sv
module win_match #(
    parameter int unsigned AW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base,
    input  logic [AW:0]   len,
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [AW-1:0] offset
);

    logic [AW:0] lim;

    always_comb begin
        lim    = {1'b0, base} + len;
        hit    = (len != '0) && (addr >= base) && ({1'b0, addr} < lim);
        offset = addr - base;
    end

    // R4: a reported hit always lies inside the window length
    a_r4_offset_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ({1'b0, offset} < len));

endmodule

// File: rtl/cpu_window_decoder.sv
module cpu_window_decoder
    import cwd_pkg::*;
#(
    parameter int unsigned GRAN_SHIFT = 21,
    parameter int unsigned LOW_W      = 15,
    parameter int unsigned HIGH_W     = 7,
    parameter int unsigned REMAP_W    = 11,
    parameter int unsigned ISD_BYTES  = 4096,
    parameter int unsigned RST_IO_LO  = 32'h080,
    parameter int unsigned RST_IO_HI  = 32'h00F,
    parameter int unsigned RST_ISD    = 32'h0A0,
    parameter int unsigned RST_REMAP  = 32'h080,
    parameter logic [63:0] HOLE_A_LO  = 64'h1E00_0000,
    parameter logic [63:0] HOLE_A_END = 64'h1F10_0000,
    parameter logic [63:0] HOLE_B_LO  = 64'h1FC0_0000,
    parameter logic [63:0] HOLE_B_END = 64'h1FD0_0000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [1:0]                    reg_idx,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    input  logic [LOW_W+GRAN_SHIFT-1:0]   cpu_addr,
    output logic                          io_hit,
    output logic                          isd_hit,
    output logic [LOW_W+GRAN_SHIFT-1:0]   win_offset,
    output logic [REMAP_W-1:0]            remap_val
);

    localparam int unsigned AW = LOW_W + GRAN_SHIFT;
    localparam logic [AW-1:0] HA_LO  = HOLE_A_LO[AW-1:0];
    localparam logic [AW-1:0] HA_END = HOLE_A_END[AW-1:0];
    localparam logic [AW-1:0] HB_LO  = HOLE_B_LO[AW-1:0];
    localparam logic [AW-1:0] HB_END = HOLE_B_END[AW-1:0];

    typedef struct packed {
        logic [LOW_W-1:0]   lo;
        logic [HIGH_W-1:0]  hi;
        logic [LOW_W-1:0]   isd;
        logic [REMAP_W-1:0] remap;
        logic [LOW_W-1:0]   map_lo;
        logic [HIGH_W-1:0]  map_hi;
        logic               map_vld;
    } st_t;

    localparam logic [LOW_W-1:0]  RLO = LOW_W'(RST_IO_LO);
    localparam logic [HIGH_W-1:0] RHI = HIGH_W'(RST_IO_HI);

    localparam st_t RST_ST = '{
        lo:      RLO,
        hi:      RHI,
        isd:     LOW_W'(RST_ISD),
        remap:   REMAP_W'(RST_REMAP),
        map_lo:  RLO,
        map_hi:  RHI,
        map_vld: (RLO[HIGH_W-1:0] <= RHI)
    };

    reg_sel_e sel;
    st_t      st_d, st_q;
    logic     io_field_wr;

    assign sel         = reg_sel_e'(reg_idx);
    assign io_field_wr = reg_wr && (sel == SEL_IO_LO || sel == SEL_IO_HI);

    // next-state computation
    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            unique case (sel)
                SEL_IO_LO: begin
                    st_d.lo    = reg_wdata[LOW_W-1:0];
                    st_d.remap = reg_wdata[REMAP_W-1:0];
                end
                SEL_IO_HI: st_d.hi    = reg_wdata[HIGH_W-1:0];
                SEL_ISD:   st_d.isd   = reg_wdata[LOW_W-1:0];
                SEL_REMAP: st_d.remap = reg_wdata[REMAP_W-1:0];
            endcase
        end
        if (io_field_wr && (st_d.lo[HIGH_W-1:0] <= st_d.hi)) begin
            st_d.map_lo  = st_d.lo;
            st_d.map_hi  = st_d.hi;
            st_d.map_vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata[31:LOW_W];

    // raw window geometry from the committed fields
    logic [AW-1:0] raw_base [NWIN];
    logic [AW:0]   raw_len  [NWIN];
    logic [AW-1:0] clip_base[NWIN];
    logic [AW:0]   clip_len [NWIN];
    logic          hit_a    [NWIN];
    logic [AW-1:0] off_a    [NWIN];

    always_comb begin
        raw_base[WIN_IO]  = AW'(st_q.map_lo) << GRAN_SHIFT;
        raw_len[WIN_IO]   = st_q.map_vld
                          ? (((AW+1)'(st_q.map_hi) + (AW+1)'(1)
                             - (AW+1)'(st_q.map_lo[HIGH_W-1:0])) << GRAN_SHIFT)
                          : '0;
        raw_base[WIN_ISD] = AW'(st_q.isd) << GRAN_SHIFT;
        raw_len[WIN_ISD]  = (AW+1)'(ISD_BYTES);
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        win_clip #(
            .AW(AW), .HA_LO(HA_LO), .HA_END(HA_END), .HB_LO(HB_LO), .HB_END(HB_END)
        ) u_clip (
            .base_i(raw_base[w]),
            .len_i (raw_len[w]),
            .base_o(clip_base[w]),
            .len_o (clip_len[w])
        );
        win_match #(.AW(AW)) u_match (
            .clk   (clk),
            .rst_n (rst_n),
            .base  (clip_base[w]),
            .len   (clip_len[w]),
            .addr  (cpu_addr),
            .hit   (hit_a[w]),
            .offset(off_a[w])
        );
    end

    always_comb begin
        io_hit     = hit_a[WIN_IO];
        isd_hit    = hit_a[WIN_ISD];
        win_offset = hit_a[WIN_ISD] ? off_a[WIN_ISD]
                   : hit_a[WIN_IO]  ? off_a[WIN_IO] : '0;
        remap_val  = st_q.remap;
        unique case (sel)
            SEL_IO_LO: reg_rdata = CFG_W'(st_q.lo);
            SEL_IO_HI: reg_rdata = CFG_W'(st_q.hi);
            SEL_ISD:   reg_rdata = CFG_W'(st_q.isd);
            SEL_REMAP: reg_rdata = CFG_W'(st_q.remap);
        endcase
    end

    // R2: a start-field write carries its low bits into the remap value
    a_r2_remap_follows_low: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel == SEL_IO_LO) |=> (remap_val == $past(reg_wdata[REMAP_W-1:0])));

    // R5: without an I/O field write the committed mapping cannot move
    a_r5_map_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !io_field_wr |=> ($stable(st_q.map_lo) && $stable(st_q.map_hi)));

    // R7: a nonzero I/O window never starts inside a reserved hole
    a_r7_start_outside_holes: assert property (@(posedge clk) disable iff (!rst_n)
        (clip_len[WIN_IO] != '0) |->
        !((clip_base[WIN_IO] >= HA_LO && clip_base[WIN_IO] < HA_END) ||
          (clip_base[WIN_IO] >= HB_LO && clip_base[WIN_IO] < HB_END)));

    // R6: the internal window never exceeds its fixed size
    a_r6_isd_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        clip_len[WIN_ISD] <= (AW+1)'(ISD_BYTES));

    // R9: no hit means a zero offset
    a_r9_offset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_hit || isd_hit) |-> (win_offset == '0));

endmodule

// File: tb/cpu_window_decoder_test.sv
`timescale 1ns/1ps
module cpu_window_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_idx = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [35:0] cpu_addr = '0;
    logic        io_hit, isd_hit;
    logic [35:0] win_offset;
    logic [10:0] remap_val;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    cpu_window_decoder uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
        .io_hit(io_hit), .isd_hit(isd_hit), .win_offset(win_offset),
        .remap_val(remap_val)
    );

    typedef struct packed {
        logic        do_wr;
        logic [1:0]  wi;
        logic [31:0] wd;
        logic [35:0] pa;
        logic        eio;
        logic        eisd;
        logic [35:0] eoff;
        logic [1:0]  ri;
        logic [31:0] erd;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        // reset mapping: R10 R4 R6
        '{1'b0, 2'd0, 32'h0, 36'h010000000, 1'b1, 1'b0, 36'h0,       2'd0, 32'h80},
        '{1'b0, 2'd0, 32'h0, 36'h011FFFFFF, 1'b1, 1'b0, 36'h1FFFFFF, 2'd1, 32'h0F},
        '{1'b0, 2'd0, 32'h0, 36'h012000000, 1'b0, 1'b0, 36'h0,       2'd3, 32'h80},
        '{1'b0, 2'd0, 32'h0, 36'h014000FFF, 1'b0, 1'b1, 36'hFFF,     2'd2, 32'hA0},
        '{1'b0, 2'd0, 32'h0, 36'h014001000, 1'b0, 1'b0, 36'h0,       2'd2, 32'hA0},
        // R5 R2: inconsistent start keeps old window, remap loads
        '{1'b1, 2'd0, 32'h0F0, 36'h010000004, 1'b1, 1'b0, 36'h4,     2'd3, 32'hF0},
        // R7 R4: start in first hole
        '{1'b1, 2'd1, 32'h78, 36'h01F100000, 1'b1, 1'b0, 36'h0,      2'd0, 32'hF0},
        '{1'b0, 2'd0, 32'h0, 36'h01E000000, 1'b0, 1'b0, 36'h0,       2'd1, 32'h78},
        '{1'b0, 2'd0, 32'h0, 36'h01F1FFFFF, 1'b1, 1'b0, 36'hFFFFF,   2'd1, 32'h78},
        '{1'b0, 2'd0, 32'h0, 36'h01F200000, 1'b0, 1'b0, 36'h0,       2'd3, 32'hF0},
        // R5
        '{1'b1, 2'd0, 32'h0FE, 36'h01F100000, 1'b1, 1'b0, 36'h0,     2'd3, 32'hFE},
        // R7: start in second hole
        '{1'b1, 2'd1, 32'h7F, 36'h01FFFFFFF, 1'b1, 1'b0, 36'h2FFFFF, 2'd1, 32'h7F},
        '{1'b0, 2'd0, 32'h0, 36'h01FCFFFFF, 1'b0, 1'b0, 36'h0,       2'd0, 32'hFE},
        '{1'b0, 2'd0, 32'h0, 36'h020000000, 1'b0, 1'b0, 36'h0,       2'd0, 32'hFE},
        // R5 R3
        '{1'b1, 2'd1, 32'hF0, 36'h01FD00000, 1'b1, 1'b0, 36'h0,      2'd1, 32'h70},
        // R8: end in first hole
        '{1'b1, 2'd0, 32'h0E0, 36'h01DFFFFFF, 1'b1, 1'b0, 36'h1FFFFFF, 2'd3, 32'hE0},
        '{1'b0, 2'd0, 32'h0, 36'h01E000000, 1'b0, 1'b0, 36'h0,       2'd0, 32'hE0},
        // R9: overlap, internal window wins
        '{1'b1, 2'd2, 32'h0E8, 36'h01D000010, 1'b1, 1'b1, 36'h10,    2'd2, 32'hE8},
        '{1'b0, 2'd0, 32'h0, 36'h01D001000, 1'b1, 1'b0, 36'h1001000, 2'd2, 32'hE8},
        // R2: direct remap write
        '{1'b1, 2'd3, 32'hFFFFFFFF, 36'h01D000010, 1'b1, 1'b1, 36'h10, 2'd3, 32'h7FF},
        '{1'b0, 2'd0, 32'h0, 36'h01C000000, 1'b1, 1'b0, 36'h0,       2'd0, 32'hE0},
        // R1: start mask
        '{1'b1, 2'd0, 32'hFFFFFFFF, 36'h01C000000, 1'b1, 1'b0, 36'h0, 2'd0, 32'h7FFF},
        '{1'b0, 2'd0, 32'h0, 36'h01C000000, 1'b1, 1'b0, 36'h0,       2'd3, 32'h7FF},
        // R11 R3: top of address space
        '{1'b1, 2'd1, 32'hFFFFFFFF, 36'hFFFFFFFFF, 1'b1, 1'b0, 36'h1FFFFF, 2'd1, 32'h7F},
        '{1'b0, 2'd0, 32'h0, 36'hFFFDFFFFF, 1'b0, 1'b0, 36'h0,       2'd1, 32'h7F},
        // R6 R9
        '{1'b1, 2'd2, 32'hFFFFFFFF, 36'hFFFE00FFF, 1'b1, 1'b1, 36'hFFF, 2'd2, 32'h7FFF},
        // R8: internal window clipped to nothing
        '{1'b1, 2'd2, 32'h0F8, 36'h01F100000, 1'b0, 1'b0, 36'h0,     2'd2, 32'hF8},
        '{1'b0, 2'd0, 32'h0, 36'h01F000000, 1'b0, 1'b0, 36'h0,       2'd2, 32'hF8}
    };

    function automatic string req_of(int i);
        if (i < 5)   return "R10 R4 R6";
        if (i == 5)  return "R5 R2";
        if (i < 10)  return "R7 R4";
        if (i == 10) return "R5";
        if (i < 14)  return "R7";
        if (i == 14) return "R5 R3";
        if (i < 17)  return "R8";
        if (i < 19)  return "R9";
        if (i < 21)  return "R2";
        if (i < 23)  return "R1";
        if (i < 25)  return "R11 R3";
        if (i == 25) return "R6 R9";
        return "R8 R6";
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state seen at the ports
        chk("R10", "remap", 64'(remap_val), 64'h80);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            reg_wr    = VEC[i].do_wr;
            reg_idx   = VEC[i].wi;
            reg_wdata = VEC[i].wd;
            @(negedge clk);
            reg_wr    = 1'b0;
            reg_idx   = VEC[i].ri;
            cpu_addr  = VEC[i].pa;
            #1;
            chk(req_of(i), $sformatf("v%0d io_hit", i), 64'(io_hit), 64'(VEC[i].eio));
            chk(req_of(i), $sformatf("v%0d isd_hit", i), 64'(isd_hit), 64'(VEC[i].eisd));
            chk(req_of(i), $sformatf("v%0d offset", i), 64'(win_offset), 64'(VEC[i].eoff));
            chk(req_of(i), $sformatf("v%0d rdata", i), 64'(reg_rdata), 64'(VEC[i].erd));
        end

        // R10: reset mid-run restores every field and both windows
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            reg_idx = 2'(k);
            #1;
            chk("R10", $sformatf("field %0d", k), 64'(reg_rdata),
                (k == 0) ? 64'h80 : (k == 1) ? 64'h0F : (k == 2) ? 64'hA0 : 64'h80);
        end
        cpu_addr = 36'h010000000;
        #1;
        chk("R10", "reset io_hit", 64'(io_hit), 64'h1);
        cpu_addr = 36'h014000000;
        #1;
        chk("R10", "reset isd_hit", 64'(isd_hit), 64'h1);

        // R1: data on the port without the strobe changes nothing
        @(negedge clk);
        reg_idx   = 2'd0;
        reg_wdata = 32'h1234;
        reg_wr    = 1'b0;
        @(negedge clk);
        #1;
        chk("R1", "no strobe", 64'(reg_rdata), 64'h80);
        chk("R1", "no strobe remap", 64'(remap_val), 64'h80);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule